// File: doc/BRIEF.md
# Handshaked Parallel Sample Output Port

This block sends receiver samples to an external host over a 16-bit parallel bus. Upstream logic hands it entries through a valid/full interface. An entry is either an I/Q sample pair from one of four channels, or a 12-bit signal-strength (gain) word from one of two gain-control loops. The entries wait in an eight-entry queue. The port then presents them one 16-bit word at a time. An I/Q pair goes out as an I word followed by a Q word. A gain word goes out as a single word.

Each word carries two labels: a flag that marks I words, and a 2-bit tag. The meaning of the tag depends on a configuration bit. In channel tagging the tag is the source channel number. In gain tagging the tag names the loop and says whether the word is a gain word.

Transfers follow a request/acknowledge handshake timed by a port clock. After reset the port clock is an input (slave mode), so the port never drives it against another device. A configuration bit switches to master mode. In master mode the block produces the port clock by dividing its core clock by 1, 2, 4 or 8.

All logic runs on the core clock. Rising and falling port-clock edges are turned into single-cycle events:
- In slave mode, the port-clock input is registered twice and its edges are detected from those two registers.
- In master mode, a phase counter produces the edges.

Top module: `hs_sample_port`

## Requirements
- R1: During and after reset, `pclk_oe`, `port_req`, `up_full`, `port_data`, `port_iq` and `port_tag` are all zero, and the port clock is taken from `pclk_in`.
- R2: When `cfg_master` is 1, `pclk_oe` goes high one core cycle later. `pclk_o` then has a period of 2^`cfg_div` core cycles and is high for half of it. When `cfg_div` is 0, `pclk_o` stays high and every core cycle is a port-clock cycle. Words are transferred on each rising edge of `pclk_o`.
- R3: `port_req` is updated only on a port-clock rising edge. It is 1 after that edge exactly when words are still waiting, so it drops on the edge that presents the last word.
- R4: `port_ack` is captured on each port-clock falling edge. A word is presented on a rising edge only if `port_req` was high and the captured acknowledge is high. A low acknowledge holds the bus unchanged.
- R5: If acknowledge is held high, the first word appears one port-clock cycle after `port_req` rises.
- R6: `port_data`, `port_iq`, `port_tag` and `port_req` change only on port-clock rising edges. In slave mode this is the second core clock edge after `pclk_in` rises.
- R7: A sample pair is sent as its I word, then its Q word. `port_iq` is 1 for an I word and 0 for a Q word or a gain word.
- R8: With `cfg_agc_tags` = 0, `port_tag` is the sample's 2-bit channel number `up_src`. A gain word is tagged with its loop index (0 or 1).
- R9: With `cfg_agc_tags` = 1, `port_tag[0]` is the loop: 0 is loop A, 1 is loop B. For a sample the loop is bit 0 of its channel; for a gain word it is `up_src[0]`. `port_tag[1]` is 0 for I/Q words and 1 for gain words. The tag mode is read when each word is presented.
- R10: A gain word puts the 12-bit `up_gain` value in `port_data[11:0]`, and `port_data[15:12]` is zero.
- R11: The queue holds 8 entries and `up_full` is 1 exactly when 8 are stored. An `up_valid` while `up_full` is 1 is ignored, and no accepted entry is ever lost.
- R12: When nothing is waiting, `port_req` stays low and `port_data`, `port_iq` and `port_tag` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: block generates the port clock; 0: port clock is an input |
| cfg_div | input | 2 | Master-mode divide select, divisor 2^value |
| cfg_agc_tags | input | 1 | 0: channel tagging; 1: gain-loop tagging |
| pclk_in | input | 1 | Port clock from the host in slave mode |
| pclk_o | output | 1 | Generated port clock in master mode |
| pclk_oe | output | 1 | Output enable for the port-clock pin |
| port_req | output | 1 | Data-waiting request to the host |
| port_ack | input | 1 | Host acknowledge, captured on port-clock falling edges |
| port_data | output | 16 | Output word |
| port_iq | output | 1 | High while an I word is on the bus |
| port_tag | output | 2 | Word tag, meaning set by `cfg_agc_tags` |
| up_valid | input | 1 | Upstream entry offered |
| up_gain_word | input | 1 | Offered entry is a gain word |
| up_src | input | 2 | Channel of a sample; bit 0 is the loop of a gain word |
| up_i | input | 16 | In-phase value of a sample |
| up_q | input | 16 | Quadrature value of a sample |
| up_gain | input | 12 | Signal-strength value of a gain word |
| up_full | output | 1 | Queue full; upstream must hold its entry |

## Verification
In slave mode the bench drives `pclk_in` itself. The design acts on a pin edge at the second core edge after the pin changes. So the bench reads the bus three core cycles after raising the pin, and again just before the next rise to confirm nothing moved in between. Acknowledge changes only while the pin is high and stays stable across the falling edge, so the captured value is known. Pushes happen in the middle of the low phase, so every push is counted before the next rise. In master mode the bus updates on the same core edge that raises `pclk_o`. The bench samples on falling core edges and, at each newly seen rise of `pclk_o`, compares the bus with the next word in its model queue.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
  localparam int WORD_W = 16;
  localparam int GAIN_W = 12;
  localparam int TAG_W  = 2;

  // one queued transfer: a sample pair or a gain word
  typedef struct packed {
    logic              is_gain;
    logic [TAG_W-1:0]  src;
    logic [WORD_W-1:0] w_i;
    logic [WORD_W-1:0] w_q;
  } pp_entry_t;
endpackage

// File: rtl/pp_clk_events.sv
`timescale 1ns/1ps
// Turns the port clock (generated or received) into core-clock edge events.
module pp_clk_events #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             pclk_in,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             pclk_o,
  output logic             pclk_oe
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W:0]   n_div;
  logic [CNT_W-1:0] cnt, last_c, half_c;
  logic             s1, s2, m_rise, m_fall;

  always_comb begin
    n_div  = (CNT_W+1)'(1) << div;
    last_c = CNT_W'(n_div - 1'b1);
    half_c = CNT_W'(n_div >> 1);
    m_rise = master && (cnt == '0);
    m_fall = master && (cnt == half_c);
    rise_evt = m_rise || (!master && s1 && !s2);
    fall_evt = m_fall || (!master && !s1 && s2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      pclk_o  <= 1'b0;
      pclk_oe <= 1'b0;
    end else begin
      s1      <= pclk_in;
      s2      <= s1;
      pclk_oe <= master;
      if (!master)
        cnt <= '0;
      else if (cnt >= last_c)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
      // divisor 1: rise and fall coincide, pin held high
      if (!master)    pclk_o <= 1'b0;
      else if (m_rise) pclk_o <= 1'b1;
      else if (m_fall) pclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_queue.sv
`timescale 1ns/1ps
// Pending-entry queue; storage has no reset so it maps to distributed RAM.
module pp_queue import pp_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  pp_entry_t        wdata,
  input  logic             pop,
  output pp_entry_t        head,
  output logic             full,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pp_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head     = mem[rd_ptr];
    full     = (cnt == CNT_W'(DEPTH));
    cnt_next = cnt + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt_next;
    end
  end
endmodule

// File: rtl/pp_shifter.sv
`timescale 1ns/1ps
// Handshake and word sequencing; all bus outputs are registers.
module pp_shifter import pp_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              ack,
  input  logic              agc_tags,
  input  pp_entry_t         head,
  input  logic              more,
  output logic              pop,
  output logic              ack_seen,
  output logic              req,
  output logic [WORD_W-1:0] data,
  output logic              iq,
  output logic [TAG_W-1:0]  tag
);
  logic shift, q_phase;

  always_comb begin
    shift = rise_evt && req && ack_seen;
    pop   = shift && (head.is_gain || q_phase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_seen <= 1'b0;
      req      <= 1'b0;
      q_phase  <= 1'b0;
      data     <= '0;
      iq       <= 1'b0;
      tag      <= '0;
    end else begin
      if (fall_evt) ack_seen <= ack;
      if (rise_evt) req <= more;
      if (shift) begin
        q_phase <= !head.is_gain && !q_phase;
        iq      <= !head.is_gain && !q_phase;
        data    <= (q_phase && !head.is_gain) ? head.w_q : head.w_i;
        tag     <= agc_tags ? {head.is_gain, head.src[0]} : head.src;
      end
    end
  end
endmodule

// File: rtl/hs_sample_port.sv
`timescale 1ns/1ps
module hs_sample_port import pp_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_agc_tags,
  input  logic              pclk_in,
  output logic              pclk_o,
  output logic              pclk_oe,
  output logic              port_req,
  input  logic              port_ack,
  output logic [WORD_W-1:0] port_data,
  output logic              port_iq,
  output logic [TAG_W-1:0]  port_tag,
  input  logic              up_valid,
  input  logic              up_gain_word,
  input  logic [TAG_W-1:0]  up_src,
  input  logic [WORD_W-1:0] up_i,
  input  logic [WORD_W-1:0] up_q,
  input  logic [GAIN_W-1:0] up_gain,
  output logic              up_full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rise_evt, fall_evt, q_push, q_pop, q_full, ack_seen;
  logic [CNT_W-1:0] q_cnt, q_cnt_next;
  pp_entry_t        q_in, q_head;

  always_comb begin
    q_push       = up_valid && !q_full;
    up_full      = q_full;
    q_in.is_gain = up_gain_word;
    q_in.src     = up_gain_word ? {{(TAG_W-1){1'b0}}, up_src[0]} : up_src;
    q_in.w_i     = up_gain_word ? {{(WORD_W-GAIN_W){1'b0}}, up_gain} : up_i;
    q_in.w_q     = up_gain_word ? '0 : up_q;
  end

  pp_clk_events #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .master(cfg_master), .div(cfg_div),
    .pclk_in(pclk_in), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .pclk_o(pclk_o), .pclk_oe(pclk_oe)
  );

  pp_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .wdata(q_in), .pop(q_pop),
    .head(q_head), .full(q_full), .cnt(q_cnt), .cnt_next(q_cnt_next)
  );

  pp_shifter u_shift (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .ack(port_ack), .agc_tags(cfg_agc_tags), .head(q_head),
    .more(q_cnt_next != '0), .pop(q_pop), .ack_seen(ack_seen),
    .req(port_req), .data(port_data), .iq(port_iq), .tag(port_tag)
  );
endmodule

// File: rtl/hs_sample_port_checker.sv
`timescale 1ns/1ps
module hs_sample_port_checker import pp_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_master,
  input logic              cfg_agc_tags,
  input logic              pclk_oe,
  input logic              port_req,
  input logic [WORD_W-1:0] port_data,
  input logic              port_iq,
  input logic [TAG_W-1:0]  port_tag,
  input logic              rise_evt,
  input logic              ack_seen,
  input logic [CNT_W-1:0]  q_cnt
);
  p_slave_pin_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_master) |-> !pclk_oe);

  p_req_drop_at_edge_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(port_req) |-> $past(rise_evt));

  p_word_needs_handshake_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_iq) |-> ($past(port_req) && $past(ack_seen)));

  p_bus_moves_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_data) |-> $past(rise_evt));

  p_iq_tag_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rise_evt && port_req && ack_seen && cfg_agc_tags) && port_iq)
      |-> !port_tag[TAG_W-1]);

  p_gain_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(rise_evt && port_req && ack_seen && cfg_agc_tags) && port_tag[TAG_W-1])
      |-> (port_data[WORD_W-1:GAIN_W] == '0));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CNT_W'(DEPTH));
endmodule

bind hs_sample_port hs_sample_port_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_agc_tags(cfg_agc_tags),
  .pclk_oe(pclk_oe), .port_req(port_req), .port_data(port_data),
  .port_iq(port_iq), .port_tag(port_tag), .rise_evt(rise_evt),
  .ack_seen(ack_seen), .q_cnt(q_cnt)
);

// File: tb/hs_sample_port_bench.sv
`timescale 1ns/1ps
module hs_sample_port_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_master = 1'b0, cfg_agc_tags = 1'b0, pclk_in = 1'b0;
  logic [1:0]  cfg_div = 2'd0;
  logic        pclk_o, pclk_oe, port_req, port_iq, up_full;
  logic        port_ack = 1'b0, up_valid = 1'b0, up_gain_word = 1'b0;
  logic [15:0] port_data, up_i = '0, up_q = '0;
  logic [1:0]  port_tag, up_src = '0;
  logic [11:0] up_gain = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [34:0] ent_q[$];
  bit          mphase = 0, mreq = 0, mack = 0;
  logic [18:0] exp_out = '0;

  always #2.5 clk = ~clk;

  hs_sample_port u_hs_sample_port (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .cfg_agc_tags(cfg_agc_tags), .pclk_in(pclk_in), .pclk_o(pclk_o),
    .pclk_oe(pclk_oe), .port_req(port_req), .port_ack(port_ack),
    .port_data(port_data), .port_iq(port_iq), .port_tag(port_tag),
    .up_valid(up_valid), .up_gain_word(up_gain_word), .up_src(up_src),
    .up_i(up_i), .up_q(up_q), .up_gain(up_gain), .up_full(up_full)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [34:0] make_ent(bit g, logic [1:0] s, logic [15:0] i,
                                           logic [15:0] q, logic [11:0] gv);
    if (g) return {1'b1, 1'b0, s[0], 4'b0, gv, 16'b0};
    return {1'b0, s, i, q};
  endfunction

  // expected {tag, iq, data} for an entry word
  function automatic logic [18:0] word_of(logic [34:0] e, bit ph, bit agc);
    logic        g = e[34];
    logic [1:0]  s = e[33:32];
    logic [15:0] d = (g || !ph) ? e[31:16] : e[15:0];
    logic [1:0]  t = agc ? {g, s[0]} : s;
    return {t, (!g && !ph), d};
  endfunction

  task automatic model_rise();
    if (mreq && mack) begin
      exp_out = word_of(ent_q[0], mphase, cfg_agc_tags);
      if (ent_q[0][34] || mphase) begin
        void'(ent_q.pop_front());
        mphase = 0;
      end else mphase = 1;
    end
    mreq = (ent_q.size() > 0);
  endtask

  task automatic chk_bus(input string r);
    chk({port_tag, port_iq, port_data} == exp_out, r,
        {13'b0, port_tag, port_iq, port_data}, {13'b0, exp_out});
    chk(port_req == mreq, "R3", port_req, mreq);
  endtask

  // one bench-driven port-clock cycle in slave mode
  task automatic slave_cycle(input bit ack_v, input bit do_push, input bit g,
                             input logic [1:0] s, input logic [15:0] i, input logic [15:0] q,
                             input logic [11:0] gv, input string lbl);
    bit acc;
    @(negedge clk) pclk_in = 1'b1;
    model_rise();
    repeat (3) @(negedge clk);
    chk_bus(lbl);
    port_ack = ack_v;
    @(negedge clk) pclk_in = 1'b0;
    mack = ack_v;
    repeat (2) @(negedge clk);
    if (do_push) begin
      chk(up_full == (ent_q.size() == DEPTH), "R11", up_full, ent_q.size() == DEPTH);
      acc = !up_full;
      up_valid = 1'b1; up_gain_word = g; up_src = s; up_i = i; up_q = q; up_gain = gv;
      @(negedge clk) up_valid = 1'b0;
      if (acc) ent_q.push_back(make_ent(g, s, i, q, gv));
    end else @(negedge clk);
    repeat (2) @(negedge clk);
    chk_bus("R6");
  endtask

  task automatic drain_slave();
    for (int n = 0; n < 40 && (ent_q.size() > 0 || mreq); n++)
      slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R4");
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R12");
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R12");
  endtask

  task automatic clock_shape(input logic [1:0] d);
    int highs = 0, rises = 0;
    bit prev;
    cfg_master = 1'b1; cfg_div = d;
    repeat (12) @(negedge clk);
    chk(pclk_oe == 1'b1, "R2", pclk_oe, 1);
    prev = pclk_o;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      if (pclk_o) highs++;
      if (pclk_o && !prev) rises++;
      prev = pclk_o;
    end
    chk(highs == ((d == 0) ? 16 : 8), "R2", highs, (d == 0) ? 16 : 8);
    chk(rises == ((d == 0) ? 0 : 16 >> d), "R2", rises, (d == 0) ? 0 : 16 >> d);
  endtask

  // master-mode stream with acknowledge held high
  task automatic master_stream(input logic [1:0] d, input int lim);
    bit pend = 0, prev, rise_seen;
    logic [34:0] pend_e;
    cfg_master = 1'b1; cfg_div = d; port_ack = 1'b1;
    repeat (24) @(negedge clk);
    mack = 1;
    prev = pclk_o;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      up_valid = 1'b0;
      if (pend) begin ent_q.push_back(pend_e); pend = 0; end
      rise_seen = (d == 0) ? 1'b1 : (pclk_o && !prev);
      prev = pclk_o;
      if (rise_seen) begin
        model_rise();
        chk_bus("R2");
      end
      if (k >= lim && ent_q.size() == 0 && !mreq) break;
      if (k < lim && ($urandom % 3) == 0) begin
        logic [31:0] r = $urandom;
        bit g = (r[3:0] < 4);
        chk(up_full == (ent_q.size() == DEPTH), "R11", up_full, ent_q.size() == DEPTH);
        up_valid = 1'b1; up_gain_word = g; up_src = r[5:4];
        up_i = $urandom; up_q = $urandom; up_gain = $urandom;
        if (!up_full) begin
          pend = 1;
          pend_e = make_ent(g, up_src, up_i, up_q, up_gain);
        end
      end
    end
    chk(ent_q.size() == 0 && !mreq, "R2", ent_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk({pclk_oe, port_req, up_full, port_iq, port_tag, port_data} == '0, "R1",
        {pclk_oe, port_req, up_full, port_iq, port_tag, port_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({pclk_oe, port_req, up_full, port_iq, port_tag, port_data} == '0, "R1",
        {pclk_oe, port_req, up_full, port_iq, port_tag, port_data}, 0);

    // R5: acknowledge held high, one sample pushed while idle
    slave_cycle(1'b1, 1'b1, 1'b0, 2'd2, 16'h1111, 16'h2222, '0, "R12");
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R5");
    chk(port_data == 16'h0000 && port_req, "R5", {port_req, port_data}, 32'h10000);
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R5");
    chk(port_data == 16'h1111 && port_iq && port_tag == 2'd2, "R7",
        {port_tag, port_iq, port_data}, {2'd2, 1'b1, 16'h1111});
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R7");
    chk(port_data == 16'h2222 && !port_iq && !port_req, "R3",
        {port_req, port_iq, port_data}, {1'b0, 1'b0, 16'h2222});

    // R11: fill with acknowledge low, then overfill and drain
    for (int n = 0; n < 10; n++)
      slave_cycle(1'b0, 1'b1, n[0], n[1:0], 16'(n * 16'h0101), 16'(16'hA000 + n),
                  12'(12'hF00 + n), "R4");
    chk(up_full == 1'b1, "R11", up_full, 1);
    chk(ent_q.size() == DEPTH, "R11", ent_q.size(), DEPTH);
    drain_slave();

    // gain words in gain-loop tagging
    cfg_agc_tags = 1'b1;
    slave_cycle(1'b1, 1'b1, 1'b1, 2'd1, '0, '0, 12'hFFF, "R9");
    slave_cycle(1'b1, 1'b1, 1'b0, 2'd3, 16'hFFFF, 16'h8001, '0, "R9");
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R10");
    chk(port_data == 16'h0FFF && port_tag == 2'b11 && !port_iq, "R10",
        {port_tag, port_iq, port_data}, {2'b11, 1'b0, 16'h0FFF});
    slave_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0, '0, '0, "R9");
    chk(port_tag == 2'b01 && port_iq, "R9", {port_tag, port_iq}, {2'b01, 1'b1});
    drain_slave();
    cfg_agc_tags = 1'b0;

    // random traffic in slave mode, tag mode flipped halfway
    for (int n = 0; n < 240; n++) begin
      logic [31:0] r = $urandom;
      if (n == 120) cfg_agc_tags = 1'b1;
      slave_cycle(r[3:0] < 11, r[4], r[7:5] < 2, r[9:8], 16'($urandom), 16'($urandom),
                  12'($urandom), cfg_agc_tags ? "R9" : "R8");
    end
    drain_slave();
    cfg_agc_tags = 1'b0;

    // master clock shapes and streams
    clock_shape(2'd1);
    clock_shape(2'd2);
    clock_shape(2'd3);
    clock_shape(2'd0);
    master_stream(2'd2, 300);
    master_stream(2'd0, 200);
    master_stream(2'd3, 300);
    port_ack = 1'b0;
    cfg_master = 1'b0;
    repeat (3) @(negedge clk);
    chk(pclk_oe == 1'b0 && pclk_o == 1'b0, "R1", {pclk_oe, pclk_o}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule